// File: doc/BRIEF.md
# Address-Filtering Packet Receiver

This block sits behind a bit-clock recovery stage and turns a serial bitstream into FIFO writes. A one-cycle `pkt_start` pulse marks the end of the preamble. After that, each `bit_stb` strobe delivers one recovered bit, most significant bit of each byte first. The first field is the destination address, which the block compares byte by byte with the local device address. A mismatch in any byte makes the block ignore the rest of the packet and wait for the next `pkt_start`.

When the address matches, the block walks through the optional sender address, the payload and a 16-bit check value. Only the payload bytes are written to an external FIFO, and each is written as soon as its last bit arrives. The block runs a CRC over the whole packet. At the end of the packet it either commits the staged payload and raises the interrupt, or tells the FIFO to drop it. A keep-on-error bit makes the block commit packets that fail the CRC check as well. The interrupt stays active until the host has emptied the FIFO. While the interrupt is active, or while the FIFO is not empty, any new packet is not received.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no FIFO write, commit or drop pulse is issued, and `irq` sits at its inactive level, which is the inverse of `cfg_int_pol`.
- R2: A packet is laid out, most significant bit of each byte first, as follows: the destination address (`cfg_addr_len` bytes, where 0 counts as 1 and 6 or 7 count as 5), then the sender address (the same length, present only when `cfg_src_en` is 1), then `cfg_pay_len` payload bytes (1 to 255), then 16 check bits.
- R3: The destination address is checked against the low `cfg_addr_len` bytes of `cfg_dev_addr`, with the most significant byte received first. If any byte differs, the block issues no write, no commit, no drop and no interrupt for that packet.
- R4: Each payload byte is written with one `fifo_we` pulse, in the cycle of the strobe that carries its last bit. Address bytes and check bytes are never written.
- R5: The check value is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, no reflection and no final XOR. It covers every byte from the first destination address byte through the last payload byte and is sent high byte first. A packet passes when the received value equals the computed one.
- R6: A passing packet produces a `fifo_commit` pulse in the cycle of the last check-bit strobe. From the next cycle `irq` sits at its active level, which equals `cfg_int_pol` (1 means active high).
- R7: A failing packet produces a `fifo_drop` pulse and leaves `irq` inactive. When `cfg_keep_bad` is 1, the block issues a commit and raises the interrupt instead.
- R8: Once raised, `irq` stays active until the first cycle without a commit in which `fifo_empty` is 1. It returns to inactive in the following cycle.
- R9: A `pkt_start` that arrives while `irq` is active or `fifo_empty` is 0 is ignored, and that whole packet causes no write, commit or drop.
- R10: If `fifo_full` is 1 when a payload byte completes, that byte is not written. The block pulses `fifo_drop`, leaves `irq` inactive and waits for the next `pkt_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | One-cycle pulse at preamble lock |
| bit_stb | input | 1 | Strobe: `bit_in` holds a valid bit |
| bit_in | input | 1 | Recovered data bit |
| cfg_dev_addr | input | 40 | Local device address, right-aligned |
| cfg_addr_len | input | 3 | Address length in bytes (1 to 5) |
| cfg_src_en | input | 1 | Sender address field present |
| cfg_pay_len | input | 8 | Payload length in bytes |
| cfg_int_pol | input | 1 | Active level of `irq` |
| cfg_keep_bad | input | 1 | Commit packets that fail the CRC check |
| fifo_full | input | 1 | FIFO cannot take another byte |
| fifo_empty | input | 1 | FIFO holds no committed byte |
| fifo_we | output | 1 | Payload byte write strobe |
| fifo_wdata | output | 8 | Payload byte |
| fifo_commit | output | 1 | Make the staged bytes visible |
| fifo_drop | output | 1 | Discard the staged bytes |
| irq | output | 1 | Packet-ready interrupt |

## Verification
The assertions rely on three things about the environment. The configuration inputs change only while the block is idle. No bit strobe arrives in the same cycle as `pkt_start`. The FIFO clears `fifo_empty` in the cycle after a commit that carries bytes. The bench's FIFO model meets the last point by construction, since it updates its counts on the same clock edge as the commit. The stimulus changes the configuration only between packets, and it always leaves an idle cycle between the start pulse and the first bit strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_DST,
    ST_SRC,
    ST_PAY,
    ST_CHK
  } rx_state_e;

  // One serial step of a left-shifting CRC-16, data bit fed into the top.
  function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                             input logic        din,
                                             input logic [15:0] poly);
    logic [15:0] sh;
    sh = {cur[14:0], 1'b0};
    return (cur[15] ^ din) ? (sh ^ poly) : sh;
  endfunction

  // Keep a configured length inside 1..hi.
  function automatic int clamp_len(input int v, input int hi);
    if (v < 1)  return 1;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/rxf_deser.sv
module rxf_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bit_stb,
  input  logic         bit_in,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (bit_stb) begin
      sr  <= {sr[W-3:0], bit_in};
      cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + CW'(1);
    end
  end

  assign byte_done = bit_stb && (cnt == CW'(W - 1));
  assign byte_val  = {sr, bit_in};
endmodule

// File: rtl/rxf_crc.sv
module rxf_crc #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc_nxt
);
  logic [15:0] crc_q;

  assign crc_nxt = rxf_pkg::crc16_step(crc_q, din, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= INIT;
    else if (init) crc_q <= INIT;
    else if (en)   crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int MAX_ADDR = 5,
  parameter int PLW      = 8,
  localparam int ALW     = $clog2(MAX_ADDR + 1),
  localparam int AW      = 8 * MAX_ADDR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pkt_start,
  input  logic           fifo_empty,
  input  logic           fifo_full,
  input  logic           byte_done,
  input  logic [7:0]     byte_val,
  input  logic [ALW-1:0] eff_len,
  input  logic           src_en,
  input  logic [PLW-1:0] pay_len,
  input  logic [AW-1:0]  dev_addr,
  input  logic           crc_zero,
  input  logic           keep_bad,
  output logic           start_ok,
  output logic           busy,
  output logic           fifo_we,
  output logic [7:0]     fifo_wdata,
  output logic           fifo_commit,
  output logic           fifo_drop,
  output logic           pending,
  output logic           addr_hit,
  output logic           addr_miss,
  output logic           crc_ok
);
  localparam int CW = (PLW > ALW) ? PLW : ALW;

  rx_state_e     state, state_n;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic [ALW-1:0] addr_idx;
  logic [7:0]    addr_byte;
  logic          last_addr, last_pay, last_chk;

  assign busy     = (state != ST_WAIT);
  assign start_ok = pkt_start && !busy && fifo_empty && !pending;

  assign addr_idx  = eff_len - ALW'(1) - cnt[ALW-1:0];
  assign last_addr = (cnt == CW'(eff_len) - CW'(1));
  assign last_pay  = (cnt == CW'(pay_len) - CW'(1));
  assign last_chk  = (cnt == CW'(1));

  always_comb begin
    addr_byte = '0;
    for (int i = 0; i < MAX_ADDR; i++) begin
      if (addr_idx == ALW'(i)) addr_byte = dev_addr[8*i +: 8];
    end
  end

  assign fifo_wdata = byte_val;

  always_comb begin
    state_n     = state;
    cnt_clr     = 1'b0;
    fifo_we     = 1'b0;
    fifo_commit = 1'b0;
    fifo_drop   = 1'b0;
    addr_hit    = 1'b0;
    addr_miss   = 1'b0;
    crc_ok      = 1'b0;
    unique case (state)
      ST_WAIT: if (start_ok) begin
        state_n = ST_DST;
        cnt_clr = 1'b1;
      end
      ST_DST: if (byte_done) begin
        if (byte_val != addr_byte) begin
          addr_miss = 1'b1;
          state_n   = ST_WAIT;
        end else if (last_addr) begin
          addr_hit = 1'b1;
          cnt_clr  = 1'b1;
          state_n  = src_en ? ST_SRC : ST_PAY;
        end
      end
      ST_SRC: if (byte_done && last_addr) begin
        cnt_clr = 1'b1;
        state_n = ST_PAY;
      end
      ST_PAY: if (byte_done) begin
        if (fifo_full) begin
          fifo_drop = 1'b1;
          state_n   = ST_WAIT;
        end else begin
          fifo_we = 1'b1;
          if (last_pay) begin
            cnt_clr = 1'b1;
            state_n = ST_CHK;
          end
        end
      end
      ST_CHK: if (byte_done && last_chk) begin
        crc_ok  = crc_zero;
        state_n = ST_WAIT;
        if (crc_zero || keep_bad) fifo_commit = 1'b1;
        else                      fifo_drop   = 1'b1;
      end
      default: state_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state <= state_n;
      if (cnt_clr)        cnt <= '0;
      else if (byte_done) cnt <= cnt + CW'(1);
      if (fifo_commit)                pending <= 1'b1;
      else if (pending && fifo_empty) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          MAX_ADDR = 5,
  parameter int          PLW      = 8,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  localparam int         ALW      = $clog2(MAX_ADDR + 1),
  localparam int         AW       = 8 * MAX_ADDR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pkt_start,
  input  logic           bit_stb,
  input  logic           bit_in,
  input  logic [AW-1:0]  cfg_dev_addr,
  input  logic [ALW-1:0] cfg_addr_len,
  input  logic           cfg_src_en,
  input  logic [PLW-1:0] cfg_pay_len,
  input  logic           cfg_int_pol,
  input  logic           cfg_keep_bad,
  input  logic           fifo_full,
  input  logic           fifo_empty,
  output logic           fifo_we,
  output logic [7:0]     fifo_wdata,
  output logic           fifo_commit,
  output logic           fifo_drop,
  output logic           irq
);
  logic           start_ok, busy, pending;
  logic           byte_done;
  logic [7:0]     byte_val;
  logic [15:0]    crc_nxt;
  logic [ALW-1:0] eff_len;
  logic           addr_hit, addr_miss, crc_ok;

  assign eff_len = ALW'(rxf_pkg::clamp_len(int'(cfg_addr_len), MAX_ADDR));

  rxf_deser #(.W(8)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .bit_stb   (bit_stb),
    .bit_in    (bit_in),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  rxf_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (start_ok),
    .en      (bit_stb && busy),
    .din     (bit_in),
    .crc_nxt (crc_nxt)
  );

  rxf_ctrl #(.MAX_ADDR(MAX_ADDR), .PLW(PLW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_start   (pkt_start),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .eff_len     (eff_len),
    .src_en      (cfg_src_en),
    .pay_len     (cfg_pay_len),
    .dev_addr    (cfg_dev_addr),
    .crc_zero    (crc_nxt == 16'h0000),
    .keep_bad    (cfg_keep_bad),
    .start_ok    (start_ok),
    .busy        (busy),
    .fifo_we     (fifo_we),
    .fifo_wdata  (fifo_wdata),
    .fifo_commit (fifo_commit),
    .fifo_drop   (fifo_drop),
    .pending     (pending),
    .addr_hit    (addr_hit),
    .addr_miss   (addr_miss),
    .crc_ok      (crc_ok)
  );

  assign irq = cfg_int_pol ? pending : !pending;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic fifo_full,
  input logic fifo_empty,
  input logic fifo_we,
  input logic fifo_commit,
  input logic fifo_drop,
  input logic irq,
  input logic cfg_int_pol,
  input logic addr_hit,
  input logic addr_miss,
  input logic crc_ok
);
  // R4
  we_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> (!fifo_full && bit_stb));

  // R7
  commit_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_commit && fifo_drop));

  // R6
  irq_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_commit |=> (irq == cfg_int_pol));

  // R5
  crc_ok_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> fifo_commit);

  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq == cfg_int_pol) && fifo_empty && !fifo_commit) |=> (irq != cfg_int_pol));

  // R9
  no_write_while_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == cfg_int_pol) |-> !fifo_we);

  // R3
  miss_ends_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !fifo_we);

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_hit && addr_miss));

  // R10
  drop_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |-> bit_stb);
endmodule

bind rx_addr_filter rxf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_stb     (bit_stb),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_we     (fifo_we),
  .fifo_commit (fifo_commit),
  .fifo_drop   (fifo_drop),
  .irq         (irq),
  .cfg_int_pol (cfg_int_pol),
  .addr_hit    (addr_hit),
  .addr_miss   (addr_miss),
  .crc_ok      (crc_ok)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int DEPTH = 8;
  localparam logic [39:0] DEV = 40'hA5_3C_96_0F_E1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 1'b0, bit_stb = 1'b0, bit_in = 1'b0;
  logic [39:0] cfg_dev_addr = DEV;
  logic [2:0]  cfg_addr_len = 3'd1;
  logic cfg_src_en = 1'b0, cfg_int_pol = 1'b1, cfg_keep_bad = 1'b0;
  logic [7:0] cfg_pay_len = 8'd1;
  logic fifo_full, fifo_empty;
  logic fifo_we, fifo_commit, fifo_drop, irq;
  logic [7:0] fifo_wdata;
  logic fifo_rd = 1'b0;

  int n_vec = 0, n_bad = 0;
  int staged = 0, committed = 0;
  int we_cnt = 0, cm_cnt = 0, dr_cnt = 0;
  logic [7:0] wr_log [0:1023];
  logic [7:0] frm [0:63];
  logic [7:0] exp_pay [0:63];
  int flen;
  int b_we, b_cm, b_dr;

  always #4 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .bit_stb(bit_stb), .bit_in(bit_in),
    .cfg_dev_addr(cfg_dev_addr), .cfg_addr_len(cfg_addr_len), .cfg_src_en(cfg_src_en),
    .cfg_pay_len(cfg_pay_len), .cfg_int_pol(cfg_int_pol), .cfg_keep_bad(cfg_keep_bad),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata), .fifo_commit(fifo_commit), .fifo_drop(fifo_drop), .irq(irq)
  );

  // FIFO model: staged bytes become visible on commit, vanish on drop.
  assign fifo_full  = (staged + committed) >= DEPTH;
  assign fifo_empty = (committed == 0);

  always_ff @(posedge clk) begin
    if (fifo_we) begin
      wr_log[we_cnt % 1024] <= fifo_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (fifo_commit) cm_cnt <= cm_cnt + 1;
    if (fifo_drop)   dr_cnt <= dr_cnt + 1;
    if (!rst_n) begin
      staged <= 0; committed <= 0;
    end else begin
      if (fifo_drop)        staged <= 0;
      else if (fifo_commit) begin committed <= committed + staged; staged <= 0; end
      else if (fifo_we)     staged <= staged + 1;
      if (fifo_rd && !fifo_commit) committed <= committed - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bytewise CRC, whole byte folded into the high half before shifting.
  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {frm[i], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  // mode: 0 good, 1 wrong address byte, 2 wrong check value, 3 payload corrupted after CRC
  task automatic send_pkt(input int al, input int se, input int plen, input int seed, input int mode);
    logic [15:0] c;
    int p = 0;
    for (int k = 0; k < al; k++) frm[p++] = DEV[8*(al-1-k) +: 8];
    if (mode == 1) frm[seed % al] = frm[seed % al] ^ 8'h10;
    if (se != 0) for (int k = 0; k < al; k++) frm[p++] = 8'hC0 + 8'(k);
    for (int k = 0; k < plen; k++) begin
      exp_pay[k] = 8'((seed * 29 + k * 53 + 7) & 255);
      frm[p++]   = exp_pay[k];
    end
    c = crc_of(p);
    if (mode == 3) frm[p-1] = frm[p-1] ^ 8'h01;
    if (mode == 2) c = c ^ 16'h0100;
    frm[p++] = c[15:8];
    frm[p++] = c[7:0];
    flen = p;
    b_we = we_cnt; b_cm = cm_cnt; b_dr = dr_cnt;
    @(negedge clk); pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    for (int i = 0; i < flen; i++)
      for (int j = 7; j >= 0; j--) send_bit(frm[i][j]);
    @(negedge clk);
  endtask

  task automatic expect_res(input string req, input int ewe, input int ecm, input int edr, input bit eirq);
    chk((we_cnt - b_we) == ewe, req, we_cnt - b_we, ewe);
    chk((cm_cnt - b_cm) == ecm, req, cm_cnt - b_cm, ecm);
    chk((dr_cnt - b_dr) == edr, req, dr_cnt - b_dr, edr);
    chk((irq == cfg_int_pol) == eirq, req, int'(irq), eirq ? int'(cfg_int_pol) : int'(!cfg_int_pol));
  endtask

  task automatic check_bytes(input string req, input int n);
    for (int k = 0; k < n; k++)
      chk(wr_log[(b_we + k) % 1024] == exp_pay[k], req, int'(wr_log[(b_we + k) % 1024]), int'(exp_pay[k]));
  endtask

  task automatic drain();
    while (committed > 0) begin
      @(negedge clk); fifo_rd = 1'b1;
      @(negedge clk); fifo_rd = 1'b0;
    end
    @(negedge clk); @(negedge clk);
    chk(irq == !cfg_int_pol, "R8 irq release", int'(irq), int'(!cfg_int_pol));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(irq == 1'b0, "R1 irq at reset", int'(irq), 0);
    chk(!fifo_we && !fifo_commit && !fifo_drop, "R1 strobes at reset",
        int'({fifo_we, fifo_commit, fifo_drop}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5 R6 R8: good packets over all lengths, sender option and polarities
    for (int pol = 0; pol < 2; pol++)
      for (int al = 1; al <= 5; al++)
        for (int se = 0; se < 2; se++) begin
          int pl = al + 2 * se + 1;
          cfg_int_pol = pol[0]; cfg_addr_len = 3'(al); cfg_src_en = se[0];
          cfg_pay_len = 8'(pl);
          @(negedge clk);
          chk(irq == !cfg_int_pol, "R6 idle level", int'(irq), int'(!cfg_int_pol));
          send_pkt(al, se, pl, al * 7 + se + pol * 3, 0);
          expect_res("R6 good packet", pl, 1, 0, 1'b1);
          check_bytes("R4 payload bytes", pl);
          drain();
        end

    // R2: out-of-range lengths clamp
    cfg_int_pol = 1'b1; cfg_src_en = 1'b0; cfg_pay_len = 8'd3;
    cfg_addr_len = 3'd0;
    send_pkt(1, 0, 3, 11, 0);
    expect_res("R2 length 0 as 1", 3, 1, 0, 1'b1);
    drain();
    cfg_addr_len = 3'd7;
    send_pkt(5, 0, 3, 12, 0);
    expect_res("R2 length 7 as 5", 3, 1, 0, 1'b1);
    drain();

    // R3: address mismatch in each byte position
    for (int al = 1; al <= 5; al++)
      for (int s = 0; s < al; s++) begin
        cfg_addr_len = 3'(al); cfg_src_en = 1'b1;
        send_pkt(al, 1, 3, s, 1);
        expect_res("R3 address miss", 0, 0, 0, 1'b0);
      end

    // R7 R5: failing check, dropped then kept
    cfg_addr_len = 3'd3; cfg_src_en = 1'b0; cfg_pay_len = 8'd4;
    for (int m = 2; m <= 3; m++) begin
      cfg_keep_bad = 1'b0;
      send_pkt(3, 0, 4, 20 + m, m);
      expect_res("R7 bad crc dropped", 4, 0, 1, 1'b0);
      chk(committed == 0, "R7 nothing visible", committed, 0);
      cfg_keep_bad = 1'b1;
      send_pkt(3, 0, 4, 30 + m, m);
      expect_res("R7 bad crc kept", 4, 1, 0, 1'b1);
      drain();
    end
    cfg_keep_bad = 1'b0;

    // R9: second packet while the first is unread
    send_pkt(3, 0, 4, 40, 0);
    expect_res("R9 first packet", 4, 1, 0, 1'b1);
    send_pkt(3, 0, 4, 41, 0);
    expect_res("R9 blocked packet", 0, 0, 0, 1'b1);
    chk(committed == 4, "R9 fifo unchanged", committed, 4);
    drain();

    // R10: payload longer than the FIFO
    cfg_pay_len = 8'd10;
    send_pkt(3, 0, 10, 50, 0);
    expect_res("R10 overflow", DEPTH, 0, 1, 1'b0);
    chk(committed == 0, "R10 nothing visible", committed, 0);
    cfg_pay_len = 8'd5;
    send_pkt(3, 0, 5, 51, 0);
    expect_res("R10 recovery", 5, 1, 0, 1'b1);
    check_bytes("R10 recovery bytes", 5);
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule